// File: doc/BRIEF.md
# Bit Deposit and Extract Unit

This unit performs two mask-steered bit permutations on 64-bit words. In deposit mode, the low-order bits of the source word are spread out, lowest first, onto the positions where the mask holds a one. Every other result position is zero. In extract mode, the unit runs the other way. It picks out the source bits that sit under the mask's ones and packs them, in their original order, into the bottom of the result. All bits above the packed field are zero.

Each mask bit is steered by its rank: the number of ones in the mask below it. A chain of ranks is built from the mask, so the result always arrives after the same number of cycles, however many mask bits are set. The unit is a three-register pipeline. It can take a new operation on every clock, and a valid flag travels with each operation.

Top module: `bitperm_core`

## Requirements
- R1: In deposit mode (opcode 0), the mask's k-th lowest set bit position receives source bit k, for every k below the mask's popcount.
- R2: In deposit mode, every result bit whose mask bit is zero reads zero.
- R3: In extract mode (opcode 1), result bit k holds the source bit found at the mask's k-th lowest set position. Result bits at or above the mask's popcount read zero.
- R4: Opcode, source and mask are captured together on the edge where in_valid is high. Later changes to in_op while in_valid is low do not affect an operation already accepted.
- R5: out_valid and out_result for an operation appear on the third rising edge, counting the edge that samples the operands. One operation may be accepted on every cycle, and back-to-back results leave in the order they were issued.
- R6: A zero mask gives a zero result in both modes.
- R7: An all-ones mask gives a result equal to the source in both modes.
- R8: Depositing an all-ones source through mask a returns a unchanged.
- R9: Depositing a source whose low N bits are zero and whose upper bits are one, through mask a, clears the N lowest set bits of a and keeps its other bits.
- R10: Extracting a from itself gives popcount(a) ones packed at the bottom. This includes a full 64 ones for an all-ones a.
- R11: out_valid is low while reset is asserted and after it is released until the first result. out_result keeps its value on every cycle where out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands present this cycle |
| in_op | input | 1 | 0 = deposit, 1 = extract |
| in_src | input | 64 | Source word |
| in_mask | input | 64 | Steering mask |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Permuted word |

## Verification
The bench builds the unit at its default width of 64 bits. At that width a full mask has 64 ones, which is one more than the 6-bit rank field can count. An extract of an all-ones word therefore tests the case where the total popcount is never stored. The same width also lets the clear-lowest-N sweep run N from 0 to 64, and lets a random mix of sparse and dense masks reach every rank value.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

  typedef enum logic {
    OP_SCATTER = 1'b0,
    OP_GATHER  = 1'b1
  } bp_op_e;

endpackage

// File: rtl/bitperm_rst_sync.sv
module bitperm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bitperm_prefix.sv
module bitperm_prefix #(
  parameter  int WIDTH = 64,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]            mask,
  output logic [WIDTH-1:0][IDX_W-1:0] rank
);

  // rank[i] counts the ones in mask[i-1:0]; only read where mask[i] is set,
  // so it never needs to reach WIDTH.
  assign rank[0] = '0;

  for (genvar g = 1; g < WIDTH; g++) begin : g_rank
    assign rank[g] = rank[g-1] + IDX_W'(mask[g-1]);
  end

endmodule

// File: rtl/bitperm_route.sv
module bitperm_route
  import bitperm_pkg::*;
#(
  parameter  int WIDTH = 64,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  bp_op_e                      op,
  input  logic [WIDTH-1:0]            src,
  input  logic [WIDTH-1:0]            mask,
  input  logic [WIDTH-1:0][IDX_W-1:0] rank,
  output logic [WIDTH-1:0]            result
);

  logic [WIDTH-1:0] scatter_w;
  logic [WIDTH-1:0] gather_w;

  always_comb begin
    scatter_w = '0;
    gather_w  = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (mask[i]) begin
        scatter_w[i]       = src[rank[i]];
        gather_w[rank[i]]  = src[i];
      end
    end
  end

  always_comb begin
    case (op)
      OP_GATHER: result = gather_w;
      default:   result = scatter_w;
    endcase
  end

endmodule

// File: rtl/bitperm_core.sv
module bitperm_core
  import bitperm_pkg::*;
#(
  parameter  int WIDTH = 64,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_op,
  input  logic [WIDTH-1:0] in_src,
  input  logic [WIDTH-1:0] in_mask,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_result
);

  logic rst_sync_n;

  bitperm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // stage 1: operand capture
  logic                        s1_valid_q, s1_valid_d;
  bp_op_e                      s1_op_q;
  logic [WIDTH-1:0]            s1_src_q, s1_mask_q;
  // stage 2: ranks computed
  logic                        s2_valid_q, s2_valid_d;
  bp_op_e                      s2_op_q;
  logic [WIDTH-1:0]            s2_src_q, s2_mask_q;
  logic [WIDTH-1:0][IDX_W-1:0] s2_rank_q;
  // stage 3: result
  logic                        s3_valid_q, s3_valid_d;
  logic [WIDTH-1:0]            s3_result_q;

  logic                        s1_en, s2_en, s3_en;
  logic [WIDTH-1:0][IDX_W-1:0] s1_rank_w;
  logic [WIDTH-1:0]            s2_result_w;

  bitperm_prefix #(.WIDTH(WIDTH)) u_prefix (
    .mask (s1_mask_q),
    .rank (s1_rank_w)
  );

  bitperm_route #(.WIDTH(WIDTH)) u_route (
    .op     (s2_op_q),
    .src    (s2_src_q),
    .mask   (s2_mask_q),
    .rank   (s2_rank_q),
    .result (s2_result_w)
  );

  // next-state and clock enables
  always_comb begin
    s1_valid_d = in_valid;
    s2_valid_d = s1_valid_q;
    s3_valid_d = s2_valid_q;
    s1_en      = in_valid;
    s2_en      = s1_valid_q;
    s3_en      = s2_valid_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
      s3_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s2_valid_q <= s2_valid_d;
      s3_valid_q <= s3_valid_d;
    end
  end

  // data registers, loaded only with a live operation
  always_ff @(posedge clk) begin
    if (s1_en) begin
      s1_op_q   <= bp_op_e'(in_op);
      s1_src_q  <= in_src;
      s1_mask_q <= in_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_en) begin
      s2_op_q   <= s1_op_q;
      s2_src_q  <= s1_src_q;
      s2_mask_q <= s1_mask_q;
      s2_rank_q <= s1_rank_w;
    end
  end

  always_ff @(posedge clk) begin
    if (s3_en) begin
      s3_result_q <= s2_result_w;
    end
  end

  assign out_valid  = s3_valid_q;
  assign out_result = s3_result_q;

endmodule

// File: rtl/bitperm_core_sva.sv
module bitperm_core_sva #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_op,
  input logic [WIDTH-1:0] in_src,
  input logic [WIDTH-1:0] in_mask,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_result
);

  // cycles since reset release, saturating at the pipeline depth
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  logic warm;
  assign warm = (age_q == 2'd3);

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 3)));

  p_scatter_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && $past(in_valid, 3) && !$past(in_op, 3))
      |-> ((out_result & ~$past(in_mask, 3)) == '0));

  p_scatter_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !$past(in_op, 3))
      |-> ($countones(out_result) <= $countones($past(in_mask, 3))));

  p_gather_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && $past(in_op, 3))
      |-> ((out_result >> $countones($past(in_mask, 3))) == '0));

  p_zero_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && ($past(in_mask, 3) == '0)) |-> (out_result == '0));

  p_full_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && ($past(in_mask, 3) == '1))
      |-> (out_result == $past(in_src, 3)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !out_valid) |-> $stable(out_result));

endmodule

bind bitperm_core bitperm_core_sva #(.WIDTH(WIDTH)) u_sva (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_src     (in_src),
  .in_mask    (in_mask),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/bitperm_core_bench.sv
module bitperm_core_bench;

  localparam int W          = 64;
  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_op;
  logic [W-1:0] in_src;
  logic [W-1:0] in_mask;
  logic         out_valid;
  logic [W-1:0] out_result;

  int n_checks = 0;
  int n_fails  = 0;
  logic [W-1:0] rng = 64'h9E37_79B9_7F4A_7C15;

  bitperm_core #(.WIDTH(W)) u_bitperm_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_src     (in_src),
    .in_mask    (in_mask),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // bit-serial reference models
  function automatic logic [W-1:0] ref_deposit(input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[i] = s[k]; k++; end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_extract(input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[k] = s[i]; k++; end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_op(input logic op, input logic [W-1:0] s, input logic [W-1:0] m);
    return op ? ref_extract(s, m) : ref_deposit(s, m);
  endfunction

  function automatic logic [W-1:0] nxt(input logic [W-1:0] x);
    logic [W-1:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one isolated operation, sampled at the negedge after the third edge
  task automatic run_one(input logic op, input logic [W-1:0] s, input logic [W-1:0] m,
                         output logic [W-1:0] res, output logic vld);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src = s; in_mask = m;
    @(negedge clk);
    in_valid = 1'b0; in_op = ~op; in_src = ~s; in_mask = ~m;
    @(negedge clk);
    @(negedge clk);
    res = out_result; vld = out_valid;
  endtask

  task automatic expect_op(input string tag, input logic op, input logic [W-1:0] s,
                           input logic [W-1:0] m, input logic [W-1:0] exp);
    logic [W-1:0] r; logic v;
    run_one(op, s, m, r, v);
    check(v == 1'b1 && r == exp, tag, r, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_op = 1'b0; in_src = '0; in_mask = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R11 valid low in reset", W'(out_valid), '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R11 valid low after reset", W'(out_valid), '0);
  endtask

  task automatic t_zero_mask;
    expect_op("R6 deposit zero mask", 1'b0, 64'hFFFF_0000_DEAD_BEEF, '0, '0);
    expect_op("R6 extract zero mask", 1'b1, 64'hFFFF_0000_DEAD_BEEF, '0, '0);
  endtask

  task automatic t_full_mask;
    expect_op("R7 deposit full mask", 1'b0, 64'h0123_4567_89AB_CDEF, '1, 64'h0123_4567_89AB_CDEF);
    expect_op("R7 extract full mask", 1'b1, 64'hFEDC_BA98_7654_3210, '1, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_deposit_ones;
    logic [W-1:0] a;
    for (int i = 0; i < 6; i++) begin
      rng = nxt(rng);
      a = (i == 0) ? 64'h8000_0000_0000_0001 : rng;
      expect_op("R8 deposit all-ones source", 1'b0, '1, a, a);
    end
  endtask

  task automatic t_clear_low;
    logic [W-1:0] a, e;
    int cnt;
    rng = nxt(rng);
    a = rng | 64'h1;
    for (int n = 0; n <= W; n += 7) begin
      e = a; cnt = 0;
      for (int i = 0; i < W; i++) if (e[i] && cnt < n) begin e[i] = 1'b0; cnt++; end
      expect_op("R9 clear lowest set bits", 1'b0, (n >= W) ? '0 : ('1 << n), a, e);
    end
    expect_op("R9 clear with N=64", 1'b0, '0, a, '0);
  endtask

  task automatic t_extract_self;
    logic [W-1:0] a;
    expect_op("R10 extract all-ones from itself", 1'b1, '1, '1, '1);
    for (int i = 0; i < 5; i++) begin
      rng = nxt(rng);
      a = rng;
      expect_op("R10 extract self", 1'b1, a, a,
                ($countones(a) >= W) ? '1 : ((64'h1 << $countones(a)) - 64'h1));
    end
  endtask

  task automatic t_random;
    logic [W-1:0] s, m;
    for (int i = 0; i < 16; i++) begin
      rng = nxt(rng); s = rng;
      rng = nxt(rng); m = rng;
      if (i % 4 == 1) m = m & nxt(m);
      if (i % 4 == 2) m = m | nxt(m);
      expect_op("R1 R2 deposit random", 1'b0, s, m, ref_deposit(s, m));
      expect_op("R3 extract random", 1'b1, s, m, ref_extract(s, m));
    end
  endtask

  task automatic t_opcode_latch;
    logic [W-1:0] s = 64'h00FF_00FF_A5A5_5A5A;
    logic [W-1:0] m = 64'hF0F0_0F0F_3C3C_C3C3;
    @(negedge clk);
    in_valid = 1'b1; in_op = 1'b1; in_src = s; in_mask = m;
    @(negedge clk);
    in_valid = 1'b0; in_op = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(out_valid && out_result == ref_extract(s, m), "R4 opcode latched with operands",
          out_result, ref_extract(s, m));
  endtask

  task automatic t_stream;
    localparam int N = 10;
    logic [W-1:0] es [N];
    logic [W-1:0] s, m;
    logic op;
    for (int c = 0; c < N + 3; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        check(out_valid == 1'b1, "R5 back-to-back valid", W'(out_valid), 64'h1);
        check(out_result == es[c-3], "R5 back-to-back result order", out_result, es[c-3]);
      end else begin
        check(out_valid == 1'b0, "R5 no early valid", W'(out_valid), '0);
      end
      if (c < N) begin
        rng = nxt(rng); s = rng;
        rng = nxt(rng); m = rng;
        op = c[0];
        es[c] = ref_op(op, s, m);
        in_valid = 1'b1; in_op = op; in_src = s; in_mask = m;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R5 valid drops after stream", W'(out_valid), '0);
  endtask

  task automatic t_hold;
    logic [W-1:0] held;
    expect_op("R11 setup", 1'b0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_FFFF_0000,
              ref_deposit(64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_FFFF_0000));
    @(negedge clk);
    held = out_result;
    in_src = '1; in_mask = '1; in_op = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && out_result == held, "R11 result held while idle", out_result, held);
  endtask

  bit finished = 0;

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_zero_mask();
    t_full_mask();
    t_deposit_ones();
    t_clear_low();
    t_extract_self();
    t_random();
    t_opcode_latch();
    t_stream();
    t_hold();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule